// File: doc/BRIEF.md
# Delayed and Periodic Trigger Source

This block drives a single-cycle trigger pulse toward a front-end sensor chip. It works in one of two modes. In the external mode it watches an asynchronous trigger line, brings it into the clock domain, and answers each rising edge with one output pulse after a programmable number of clock cycles. In the internal mode it makes triggers on its own, on a fixed grid. A free-running prescaler produces one tick every `PRESCALE` cycles, which is 5 µs at 40 MHz. The gap input counts how many ticks separate two triggers.

The delay, gap, mode and enable values come in as plain inputs from a register bank held elsewhere. When the enable is low, or when the mode changes, any delay in progress is dropped and the period counter starts again from zero. No trigger leaves the block unless the enable is high.

Top module: `trig_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `trig_out` is low. No pulse appears until a trigger source is enabled.
- R2: With `cfg_enable`=1 and `cfg_internal`=0, a rising edge on `trig_in` passes two synchronizer flops and one edge-detect flop. `trig_out` then pulses for exactly one cycle, 3+n cycles after the edge was first sampled, where n is `cfg_delay`. For n=0 the pulse comes one cycle after the edge is detected.
- R3: The delay uses the full 16-bit range. The values 1, 5, 1000 and 65535 each add exactly that many cycles.
- R4: A rising edge that is detected while a delay is still counting is ignored. It neither restarts the count nor adds a pulse.
- R5: Only rising edges start a delay. Holding `trig_in` high or bringing it low produces no further pulse.
- R6: With `cfg_enable`=1 and `cfg_internal`=1, the first pulse comes `cfg_gap`×200 cycles after the mode became active. Later pulses follow every `cfg_gap`×200 cycles.
- R7: A `cfg_gap` of 0 behaves as 1, giving a period of 200 cycles.
- R8: In the internal mode `trig_in` has no effect. In the external mode no periodic pulses are made.
- R9: With `cfg_enable`=0, `trig_out` stays low whatever the other inputs do.
- R10: Clearing `cfg_enable` or changing `cfg_internal` aborts a pending delay and restarts the period counter from zero.
- R11: Every pulse on `trig_out` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (40 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous external trigger line |
| cfg_delay | input | 16 | Delay from detected edge to pulse, in cycles |
| cfg_gap | input | 16 | Internal trigger period in prescaler ticks (0 treated as 1) |
| cfg_internal | input | 1 | 1 selects the periodic generator, 0 the external line |
| cfg_enable | input | 1 | Global trigger enable |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
The bench measures the exact latency from an input edge to the output pulse for delays of 0, 1, 5, 1000 and the full 65535. A counter that is off by one, or that is truncated to fewer bits, shows up as a wrong latency. Edges are fed in during a running countdown; a design that restarted on them would move the pulse later or emit two. In the internal mode it checks the first-pulse latency and the period for gaps 0, 1 and 3, where a zero gap handled wrongly gives either no pulse or a wrapped 65536-tick period. It also drops the enable or flips the mode partway through a delay and partway through a period: a design that kept its count would fire early or fire a stale pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;
   localparam int unsigned TRIG_CNT_W      = 16;
   localparam int unsigned TRIG_TICK_DIV   = 200;
   localparam int unsigned TRIG_SYNC_DEPTH = 2;

   typedef enum logic {
      SRC_EXTERNAL = 1'b0,
      SRC_INTERNAL = 1'b1
   } trig_src_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("trig_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              hist;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hist <= 1'b0;
      else        hist <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~hist;

   // R5: a detected rising edge can never last two cycles
   p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
   parameter int unsigned DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rise,
   input  logic [DLY_W-1:0] delay,
   output logic             pulse
);
   if (DLY_W < 1) begin : g_bad_width
      $error("trig_delay_line: DLY_W must be at least 1");
   end

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] remain;
   logic             busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         busy   <= 1'b0;
         pulse  <= 1'b0;
      end else if (!run) begin
         remain <= '0;
         busy   <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (busy) begin
            remain <= remain - ONE;
            if (remain == ONE) begin
               busy  <= 1'b0;
               pulse <= 1'b1;
            end
         end else if (rise) begin
            if (delay == '0) begin
               pulse <= 1'b1;
            end else begin
               busy   <= 1'b1;
               remain <= delay;
            end
         end
      end
   end

   // R4: while counting, an incoming edge does not reload the counter
   p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && busy && remain != ONE) |=> (busy && remain == $past(remain) - ONE));

   // R2: zero delay answers on the very next cycle
   p_zero_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !busy && rise && delay == '0) |=> pulse);

   // R10: losing run drops any pending count
   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!busy && !pulse));
endmodule

// File: rtl/trig_periodic.sv
module trig_periodic #(
   parameter int unsigned GAP_W    = 16,
   parameter int unsigned PRESCALE = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [GAP_W-1:0] gap,
   output logic             pulse
);
   if (PRESCALE < 2) begin : g_bad_prescale
      $error("trig_periodic: PRESCALE must be at least 2");
   end
   if (GAP_W < 1) begin : g_bad_width
      $error("trig_periodic: GAP_W must be at least 1");
   end

   localparam int unsigned     PRE_W   = $clog2(PRESCALE);
   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

   logic [PRE_W-1:0] pre;
   logic [GAP_W-1:0] ticks;
   logic [GAP_W-1:0] gap_eff;
   logic             tick;

   assign gap_eff = (gap == '0) ? GAP_W'(1) : gap;
   assign tick    = (pre == PRE_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pre   <= '0;
         ticks <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            pre <= '0;
            if (ticks >= gap_eff - GAP_W'(1)) begin
               ticks <= '0;
               pulse <= 1'b1;
            end else begin
               ticks <= ticks + GAP_W'(1);
            end
         end else begin
            pre <= pre + PRE_W'(1);
         end
      end
   end

   // R6: the prescaler never leaves its range
   p_pre_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pre <= PRE_TOP);

   // R6: a periodic pulse only follows a prescaler tick
   p_pulse_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> ($past(pre) == PRE_TOP && $past(run)));

   // R11: periodic pulses are single-cycle
   p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/trig_gen.sv
module trig_gen
   import trig_pkg::*;
#(
   parameter int unsigned CNT_W      = TRIG_CNT_W,
   parameter int unsigned TICK_DIV   = TRIG_TICK_DIV,
   parameter int unsigned SYNC_DEPTH = TRIG_SYNC_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_gap,
   input  logic             cfg_internal,
   input  logic             cfg_enable,
   output logic             trig_out
);
   trig_src_e src;
   logic      run_ext;
   logic      run_int;
   logic      rise;
   logic      dly_pulse;
   logic      per_pulse;

   assign src     = trig_src_e'(cfg_internal);
   assign run_ext = cfg_enable && (src == SRC_EXTERNAL);
   assign run_int = cfg_enable && (src == SRC_INTERNAL);

   trig_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (trig_in),
      .rise     (rise)
   );

   trig_delay_line #(.DLY_W(CNT_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_ext),
      .rise  (rise),
      .delay (cfg_delay),
      .pulse (dly_pulse)
   );

   trig_periodic #(.GAP_W(CNT_W), .PRESCALE(TICK_DIV)) u_period (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_int),
      .gap   (cfg_gap),
      .pulse (per_pulse)
   );

   assign trig_out = run_int ? per_pulse : (run_ext & dly_pulse);

   // R9: both sources are emptied once the enable goes low
   p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!dly_pulse && !per_pulse));

   // R8: external-mode pulses never coexist with the periodic source
   p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dly_pulse && per_pulse));
endmodule

// File: tb/trig_gen_tb.sv
module trig_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_in = 1'b0;
   logic [15:0] cfg_delay = '0;
   logic [15:0] cfg_gap = 16'd20;
   logic        cfg_internal = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        trig_out;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   trig_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_in      (trig_in),
      .cfg_delay    (cfg_delay),
      .cfg_gap      (cfg_gap),
      .cfg_internal (cfg_internal),
      .cfg_enable   (cfg_enable),
      .trig_out     (trig_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(input int maxc, output int lat);
      lat = -1;
      for (int i = 1; i <= maxc; i++) begin
         @(negedge clk);
         if (trig_out) begin
            lat = i;
            break;
         end
      end
   endtask

   task automatic count_pulses(input int cycles, output int c);
      c = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (trig_out) c++;
      end
   endtask

   task automatic idle_all();
      @(negedge clk);
      cfg_enable   = 1'b0;
      cfg_internal = 1'b0;
      trig_in      = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      int c;
      count_pulses(10, c);
      chk(c == 0 && trig_out == 1'b0, "R1 reset state", c, 0);
   endtask

   task automatic t_ext_delay(input int n, input string req);
      int lat;
      idle_all();
      cfg_delay  = 16'(n);
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);
      trig_in = 1'b1;
      measure(n + 20, lat);
      chk(lat == n + 3, req, lat, n + 3);
      @(negedge clk);
      chk(trig_out == 1'b0, "R11 single-cycle external pulse", int'(trig_out), 0);
   endtask

   task automatic t_levels();
      int c;
      // trig_in is still high from the previous test: holding gives nothing
      count_pulses(20, c);
      chk(c == 0, "R5 held level", c, 0);
      trig_in = 1'b0;
      count_pulses(20, c);
      chk(c == 0, "R5 falling edge", c, 0);
   endtask

   task automatic t_ignore_edge();
      int first = -1;
      int c = 0;
      idle_all();
      cfg_delay  = 16'd50;
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);
      trig_in = 1'b1;
      for (int i = 1; i <= 120; i++) begin
         @(negedge clk);
         if (trig_out) begin
            c++;
            if (first < 0) first = i;
         end
         trig_in = (i < 3) || (i >= 10 && i < 13);
      end
      chk(c == 1, "R4 edge during countdown adds no pulse", c, 1);
      chk(first == 53, "R4 countdown not restarted", first, 53);
   endtask

   task automatic t_disabled();
      int c;
      idle_all();
      cfg_delay = 16'd0;
      cfg_gap   = 16'd1;
      for (int k = 0; k < 4; k++) begin
         trig_in = 1'b1;
         repeat (4) @(negedge clk);
         trig_in = 1'b0;
         repeat (4) @(negedge clk);
      end
      cfg_internal = 1'b1;
      count_pulses(500, c);
      chk(c == 0, "R9 no output while disabled", c, 0);
   endtask

   task automatic t_internal(input int gap, input int per, input string req);
      int lat;
      idle_all();
      cfg_gap      = 16'(gap);
      cfg_internal = 1'b1;
      cfg_enable   = 1'b1;
      measure(per + 50, lat);
      chk(lat == per, {req, " first pulse"}, lat, per);
      @(negedge clk);
      chk(trig_out == 1'b0, "R11 single-cycle periodic pulse", int'(trig_out), 0);
      measure(per + 50, lat);
      chk(lat == per - 1, {req, " period"}, lat + 1, per);
   endtask

   task automatic t_int_ignores_input();
      int c;
      idle_all();
      cfg_gap      = 16'd20;
      cfg_delay    = 16'd0;
      cfg_internal = 1'b1;
      cfg_enable   = 1'b1;
      for (int k = 0; k < 10; k++) begin
         trig_in = 1'b1;
         repeat (5) @(negedge clk);
         trig_in = 1'b0;
         repeat (5) @(negedge clk);
      end
      count_pulses(200, c);
      chk(c == 0, "R8 trig_in ignored in internal mode", c, 0);
   endtask

   task automatic t_ext_no_periodic();
      int c;
      idle_all();
      cfg_gap    = 16'd1;
      cfg_enable = 1'b1;
      count_pulses(1000, c);
      chk(c == 0, "R8 no periodic pulses in external mode", c, 0);
   endtask

   task automatic t_abort_delay(input bit by_mode);
      int c;
      idle_all();
      cfg_delay  = 16'd100;
      cfg_gap    = 16'd20;
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);
      trig_in = 1'b1;
      repeat (20) @(negedge clk);
      trig_in = 1'b0;
      if (by_mode) cfg_internal = 1'b1;
      else         cfg_enable   = 1'b0;
      @(negedge clk);
      cfg_internal = 1'b0;
      cfg_enable   = 1'b1;
      count_pulses(300, c);
      chk(c == 0, by_mode ? "R10 mode change aborts delay" : "R10 disable aborts delay", c, 0);
   endtask

   task automatic t_restart_period(input bit by_mode);
      int lat;
      int c;
      idle_all();
      cfg_gap      = 16'd2;
      cfg_internal = 1'b1;
      cfg_enable   = 1'b1;
      count_pulses(300, c);
      if (by_mode) cfg_internal = 1'b0;
      else         cfg_enable   = 1'b0;
      @(negedge clk);
      cfg_internal = 1'b1;
      cfg_enable   = 1'b1;
      measure(500, lat);
      chk(c == 0 && lat == 400,
          by_mode ? "R10 mode change restarts period" : "R10 disable restarts period", lat, 400);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ext_delay(0, "R2 zero delay");
      t_levels();
      t_ext_delay(1, "R3 delay 1");
      t_ext_delay(5, "R3 delay 5");
      t_ext_delay(1000, "R3 delay 1000");
      t_ext_delay(65535, "R3 delay 65535");
      t_ignore_edge();
      t_disabled();
      t_internal(1, 200, "R6 gap 1");
      t_internal(3, 600, "R6 gap 3");
      t_internal(0, 200, "R7 gap 0");
      t_int_ignores_input();
      t_ext_no_periodic();
      t_abort_delay(1'b0);
      t_abort_delay(1'b1);
      t_restart_period(1'b0);
      t_restart_period(1'b1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule